// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block produces one pulse-width modulated output from a counter driven through a programmable clock divider. Software reaches it through four word registers: control, status, a duty-sample port and a period register. Duty values written to the sample port are held in a small queue. The block takes one value from the queue at the start of a period and can apply each value for a programmable number of periods. This lets software stream a sequence of duty cycles without having to time each write to a period boundary.

A period lasts the period register value plus two counter ticks. In normal polarity the output is high from the start of the period until the counter reaches the active duty value. The output can also be inverted or switched off. While the block is disabled, the output is low whatever the polarity. A self-clearing software reset empties the queue and returns every register to zero. Status flags report compare and rollover events and report writes that were refused.

Top module: `fifo_pwm`

## Requirements
- R1: The registers sit at byte offsets control 0x00, status 0x04, sample 0x0C and period 0x10. Each reads zero after reset, and the output is low.
- R2: With prescaler field value S and period value P, a period lasts (P+2)*(S+1) clock cycles. In normal mode the output is high for min(D,P+2)*(S+1) of those cycles, where D is the active duty value.
- R3: An all-ones period value behaves exactly like all-ones minus one.
- R4: The prescaler is control bits [15:4] and holds the divide ratio minus one, so 0 divides by 1.
- R5: Control bit 0 enables the block. While it is 0 the output is low in every polarity mode.
- R6: Control bits [19:18] select the output mode: 0 is normal, 1 is inverted (the complement of normal while enabled), and 2 or 3 is off (output low).
- R7: Sample writes enter a queue of DEPTH entries (4 by default), and status bits [2:0] give its occupancy. A write to a full queue is dropped and sets status bit 3.
- R8: On enable the oldest queued sample becomes active. Control bits [2:1] = k make each sample last 2^k periods. After that the next sample is popped at the rollover. If the queue is empty, the active value is kept.
- R9: Writing 1 to control bit 3 clears all registers and the queue at once. Bit 3 then reads 1 for RST_CYCLES cycles and clears itself. Writes are ignored during this time, and a sample write during it sets status bit 6.
- R10: Status bit 5 sets on a compare match and status bit 4 sets on a counter rollover. Writing 1 to any of status bits 3 to 6 clears that bit.
- R11: Reading the sample register returns the active duty value while the block is enabled and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench sweeps prescaler, period, duty and mode over small values. The duty values include 0 (always low), P+1, P+2 and P+3; the last two must give an output that stays high, and a compare written with the wrong inequality or the wrong period length would shift the high-cycle count. With an 8-bit period, the value 0xFF is checked against a 256-cycle period, so a missing clamp would show up as one extra low cycle per period. For every repeat setting, per-period high counts are checked to switch samples only after 2^k periods and then to hold the last value when the queue runs dry, which catches an off-by-one repeat counter or a pop from an empty queue. The overflow, write-1-to-clear and software-reset sequences confirm that a dropped write leaves the occupancy at full, and that the reset bit stays visible for its whole window before it clears.

// File: rtl/fifo_pwm_pkg.sv
package fifo_pwm_pkg;

    localparam int ADDR_W = 5;
    localparam int PRE_W  = 12;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] A_SAMPLE = 5'h0C;
    localparam logic [ADDR_W-1:0] A_PERIOD = 5'h10;

    localparam int C_SWR  = 3;
    localparam int S_FULW = 3;
    localparam int S_ROV  = 4;
    localparam int S_CMP  = 5;
    localparam int S_WERR = 6;

    typedef enum logic [1:0] {
        OM_NORMAL = 2'd0,
        OM_INVERT = 2'd1,
        OM_OFF    = 2'd2,
        OM_OFF2   = 2'd3
    } out_mode_e;

    typedef struct packed {
        out_mode_e        mode;
        logic [PRE_W-1:0] presc;
        logic [1:0]       rpt;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic werr;
        logic cmp;
        logic rov;
        logic fulw;
    } flags_t;

    function automatic logic [2:0] reps_last(input logic [1:0] rpt);
        return 3'((4'd1 << rpt) - 4'd1);
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [31:0] w);
        ctrl_t c;
        c.en    = w[0];
        c.rpt   = w[2:1];
        c.presc = w[15:4];
        c.mode  = out_mode_e'(w[19:18]);
        return c;
    endfunction

endpackage

// File: rtl/fifo_pwm_fifo.sv
module fifo_pwm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == LVL_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/fifo_pwm_timebase.sv
module fifo_pwm_timebase #(
    parameter int PER_W = 16,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    input  logic [PER_W-1:0] per_raw,
    input  logic [PER_W-1:0] active,
    output logic             started,
    output logic             start_evt,
    output logic             tick,
    output logic             wrap,
    output logic             cmp_evt,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] last
);
    localparam logic [PER_W-1:0] PER_ONES = '1;

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] cnt_q, per_eff;
    logic             started_q;

    assign per_eff   = (per_raw == PER_ONES) ? PER_ONES - 1'b1 : per_raw;
    assign last      = per_eff + 1'b1;
    assign started   = started_q;
    assign start_evt = run && !started_q;
    assign tick      = started_q && (pre_q == presc);
    assign wrap      = tick && (cnt_q >= last);
    assign cmp_evt   = tick && (cnt_q == active);
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            started_q <= 1'b0;
            pre_q     <= '0;
            cnt_q     <= '0;
        end else if (!started_q) begin
            started_q <= 1'b1;
            pre_q     <= '0;
            cnt_q     <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/fifo_pwm_drive.sv
module fifo_pwm_drive
    import fifo_pwm_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             run,
    input  out_mode_e        mode,
    input  logic [PER_W-1:0] cnt,
    input  logic [PER_W-1:0] active,
    output logic             pwm_out
);
    logic below;
    assign below = (cnt < active);

    always_comb begin
        pwm_out = 1'b0;
        if (run) begin
            unique case (mode)
                OM_NORMAL: pwm_out = below;
                OM_INVERT: pwm_out = !below;
                default:   pwm_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
    import fifo_pwm_pkg::*;
#(
    parameter int PER_W      = 16,
    parameter int DEPTH      = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int RC_W  = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    ctrl_t            ctrl_q;
    flags_t           flags_q;
    logic [PER_W-1:0] per_q, active_q;
    logic             busy_q;
    logic [RC_W-1:0]  rc_q;
    logic [2:0]       rep_q;

    logic             sel_ctrl, sel_stat, sel_samp, sel_per, swr_go;
    logic             started, start_evt, tick, wrap, cmp_evt, seq_adv;
    logic [PER_W-1:0] tb_cnt, tb_last, fifo_dout;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full, fifo_empty, push, pop;
    logic             en_w;
    logic [1:0]       mode_w;

    assign sel_ctrl = bus_wr && (bus_addr == A_CTRL)   && !busy_q;
    assign sel_stat = bus_wr && (bus_addr == A_STAT)   && !busy_q;
    assign sel_samp = bus_wr && (bus_addr == A_SAMPLE);
    assign sel_per  = bus_wr && (bus_addr == A_PERIOD) && !busy_q;
    assign swr_go   = sel_ctrl && bus_wdata[C_SWR];

    assign en_w   = ctrl_q.en;
    assign mode_w = ctrl_q.mode;

    assign seq_adv = start_evt || (wrap && (rep_q == reps_last(ctrl_q.rpt)));
    assign push    = sel_samp && !busy_q;
    assign pop     = seq_adv && !fifo_empty && !swr_go;

    fifo_pwm_fifo #(.W(PER_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (swr_go),
        .push  (push),
        .pop   (pop),
        .din   (bus_wdata[PER_W-1:0]),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    fifo_pwm_timebase #(.PER_W(PER_W), .PRE_W(PRE_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.en),
        .presc     (ctrl_q.presc),
        .per_raw   (per_q),
        .active    (active_q),
        .started   (started),
        .start_evt (start_evt),
        .tick      (tick),
        .wrap      (wrap),
        .cmp_evt   (cmp_evt),
        .cnt       (tb_cnt),
        .last      (tb_last)
    );

    fifo_pwm_drive #(.PER_W(PER_W)) u_drive (
        .run     (ctrl_q.en && started),
        .mode    (ctrl_q.mode),
        .cnt     (tb_cnt),
        .active  (active_q),
        .pwm_out (pwm_out)
    );

    // control, period and software reset sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            busy_q <= 1'b0;
            rc_q   <= '0;
        end else if (swr_go) begin
            ctrl_q <= '0;
            per_q  <= '0;
            busy_q <= 1'b1;
            rc_q   <= RC_W'(RST_CYCLES-1);
        end else begin
            if (sel_ctrl) ctrl_q <= ctrl_decode(bus_wdata);
            if (sel_per)  per_q  <= bus_wdata[PER_W-1:0];
            if (busy_q) begin
                if (rc_q == '0) busy_q <= 1'b0;
                else            rc_q   <= rc_q - 1'b1;
            end
        end
    end

    // sample sequencing: repeat counter and active compare value
    always_ff @(posedge clk) begin
        if (rst || swr_go) begin
            rep_q    <= '0;
            active_q <= '0;
        end else begin
            if (start_evt)
                rep_q <= '0;
            else if (wrap)
                rep_q <= seq_adv ? 3'd0 : rep_q + 3'd1;
            if (pop) active_q <= fifo_dout;
        end
    end

    // sticky status flags, write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst || swr_go) begin
            flags_q <= '0;
        end else begin
            flags_q.fulw <= (push && fifo_full) ||
                            (flags_q.fulw && !(sel_stat && bus_wdata[S_FULW]));
            flags_q.rov  <= wrap ||
                            (flags_q.rov  && !(sel_stat && bus_wdata[S_ROV]));
            flags_q.cmp  <= cmp_evt ||
                            (flags_q.cmp  && !(sel_stat && bus_wdata[S_CMP]));
            flags_q.werr <= (sel_samp && busy_q) ||
                            (flags_q.werr && !(sel_stat && bus_wdata[S_WERR]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[0]     = ctrl_q.en;
                bus_rdata[2:1]   = ctrl_q.rpt;
                bus_rdata[C_SWR] = busy_q;
                bus_rdata[15:4]  = ctrl_q.presc;
                bus_rdata[19:18] = ctrl_q.mode;
            end
            A_STAT: begin
                bus_rdata[LVL_W-1:0] = fifo_level;
                bus_rdata[S_FULW]    = flags_q.fulw;
                bus_rdata[S_ROV]     = flags_q.rov;
                bus_rdata[S_CMP]     = flags_q.cmp;
                bus_rdata[S_WERR]    = flags_q.werr;
            end
            A_SAMPLE: if (ctrl_q.en) bus_rdata[PER_W-1:0] = active_q;
            A_PERIOD: bus_rdata[PER_W-1:0] = per_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk #(
    parameter int PER_W = 16,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en,
    input logic [1:0]                 mode,
    input logic                       pwm_out,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       busy,
    input logic [PER_W-1:0]           cnt,
    input logic [PER_W-1:0]           last
);
    p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out);

    p_mode_off_r6: assert property (@(posedge clk) disable iff (rst)
        (en && mode[1]) |-> !pwm_out);

    p_level_cap_r7: assert property (@(posedge clk) disable iff (rst)
        level <= ($clog2(DEPTH+1))'(DEPTH));

    p_level_step_r7: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level + 1'b1 == $past(level)) || (level == '0));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        $stable(last) |=> (cnt <= last));

    p_swr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (level == '0 && !en));
endmodule

bind fifo_pwm fifo_pwm_chk #(.PER_W(PER_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en_w),
    .mode    (mode_w),
    .pwm_out (pwm_out),
    .level   (fifo_level),
    .busy    (busy_q),
    .cnt     (tb_cnt),
    .last    (tb_last)
);

// File: tb/fifo_pwm_bench.sv
module fifo_pwm_bench;
    localparam int PER_W = 8;
    localparam int DEPTH = 4;
    localparam int RSTC  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    fifo_pwm #(.PER_W(PER_W), .DEPTH(DEPTH), .RST_CYCLES(RSTC)) u_fifo_pwm (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FIFO_PWM FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            h += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] mk(input int en, input int rpt, input int ps, input int mode);
        return 32'(en) | (32'(rpt) << 1) | (32'(ps) << 4) | (32'(mode) << 18);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FIFO_PWM FAIL watchdog: got 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int h, per, d, deff, win, reps;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        rd(5'h00, v); check("R1 ctrl", v, 0);
        rd(5'h04, v); check("R1 stat", v, 0);
        rd(5'h0C, v); check("R1 sample", v, 0);
        rd(5'h10, v); check("R1 period", v, 0);
        check("R1 output", pwm_out, 0);

        // R2 R4 R5 R6 sweep
        for (int ps = 0; ps < 3; ps++) begin
            for (int pi = 0; pi < 4; pi++) begin
                per = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 5;
                win = 2 * (per + 2) * (ps + 1);
                for (int di = 0; di < 5; di++) begin
                    d = (di == 0) ? 0 : (di == 1) ? 1 : per + di - 1;
                    deff = (d < per + 2) ? d : per + 2;
                    for (int m = 0; m < 3; m++) begin
                        wr(5'h00, 0);
                        wr(5'h10, 32'(per));
                        wr(5'h0C, 32'(d));
                        wr(5'h00, mk(1, 0, ps, m));
                        repeat (3) @(negedge clk);
                        count_high(win, h);
                        if (m == 0)      check("R2 R4 normal", h, 2 * deff * (ps + 1));
                        else if (m == 1) check("R6 inverted", h, win - 2 * deff * (ps + 1));
                        else             check("R6 off", h, 0);
                    end
                    wr(5'h00, mk(0, 0, ps, 1));
                    count_high(win, h);
                    check("R5 disabled", h, 0);
                end
            end
        end

        // R10: compare and rollover flags, write-one-to-clear
        wr(5'h00, 0);
        rd(5'h04, v); check("R10 flags set", v, 32'h30);
        wr(5'h04, 32'h30);
        rd(5'h04, v); check("R10 flags cleared", v, 0);

        // R3: all-ones period acts as all-ones minus one (256-cycle period)
        wr(5'h10, 32'hFF);
        wr(5'h0C, 32'hFE);
        wr(5'h00, mk(1, 0, 0, 0));
        repeat (3) @(negedge clk);
        count_high(512, h);
        check("R3 clamp", h, 508);
        wr(5'h00, 0);

        // R8 R11: repeat counts and queue hold
        wr(5'h10, 6);
        for (int k = 0; k < 4; k++) begin
            reps = 1 << k;
            wr(5'h00, 0);
            wr(5'h0C, 2);
            wr(5'h0C, 5);
            rd(5'h04, v); check("R7 level two", v[2:0], 2);
            wr(5'h00, mk(1, k, 0, 0));
            @(negedge clk);
            rd(5'h0C, v); check("R11 sample enabled", v, 2);
            for (int w = 0; w <= 2 * reps; w++) begin
                count_high(8, h);
                check("R8 repeat window", h, (w < reps) ? 2 : 5);
            end
            rd(5'h04, v); check("R8 queue drained", v[2:0], 0);
            wr(5'h00, 0);
            rd(5'h0C, v); check("R11 sample disabled", v, 0);
        end
        wr(5'h04, 32'h30);

        // R7: overflow
        for (int i = 0; i < 4; i++) wr(5'h0C, 32'(i + 1));
        rd(5'h04, v); check("R7 full level", v, 4);
        wr(5'h0C, 9);
        rd(5'h04, v); check("R7 overflow flag", v, 32'h0C);
        wr(5'h04, 32'h08);
        rd(5'h04, v); check("R7 overflow cleared", v, 4);

        // R9: software reset
        wr(5'h10, 32'hFF);
        wr(5'h00, mk(1, 2, 5, 1) | 32'h8);
        rd(5'h00, v); check("R9 busy reads one", v, 32'h8);
        wr(5'h0C, 3);
        rd(5'h04, v); check("R9 write during reset", v, 32'h40);
        rd(5'h00, v); check("R9 still busy", v, 32'h8);
        repeat (4) @(negedge clk);
        rd(5'h00, v); check("R9 self clear", v, 0);
        rd(5'h10, v); check("R9 period cleared", v, 0);
        rd(5'h04, v); check("R9 queue empty", v, 32'h40);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule